// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block produces the line and frame timing for a parallel LCD panel. Three 32-bit timing words and one control word are loaded through a simple write port. The words set the horizontal geometry, the vertical geometry and the pixel clock divisor. From these the block derives a pixel clock enable, a pixel clock output, line sync, frame sync and an output enable. It also gives the current pixel and line coordinates to a downstream pixel fetch stage.

Every line runs in a fixed order: line sync pulse, then a wait before the active pixels, then the active pixels, then a wait after them. Every frame runs in the same pattern, counted in whole lines: frame sync pulse, wait before, active lines, wait after. Timing fields use biased encodings. A new configuration takes effect only at the next frame boundary, so a frame in progress is never disturbed.

Top module: `lcd_timing_gen`

## Requirements
- R1: The horizontal word (select 1) encodes active pixels per line minus 16 in bits 9:0, line sync width minus 1 in bits 15:10, trailing line wait minus 1 in bits 23:16 and leading line wait minus 1 in bits 31:24. All horizontal counts are in pixel clock periods.
- R2: The vertical word (select 2) encodes active lines minus 1 in bits 9:0 and frame sync width minus 1 in bits 15:10. It holds the trailing frame wait (unbiased) in bits 23:16 and the leading frame wait (unbiased) in bits 31:24. All vertical counts are in whole lines.
- R3: Bits 7:0 of the clock word (select 3) hold a divisor code D. The pixel clock period is 2·D+4 input clocks, and `pix_en` pulses for exactly one input clock per period.
- R4: Bit 20 of the clock word sets frame sync polarity and bit 21 sets line sync polarity, where 0 means active low and 1 means active high.
- R5: Bit 22 of the clock word picks the `pclk_out` edge on which the outputs change. With 0, `pclk_out` reads 1 in the first cycle after a change; with 1 it reads 0. `pclk_out` is high for D+2 clocks of each period before any inversion.
- R6: Bit 0 of the control word (select 0) enables the block. While it is clear, or after reset, the counters are held at zero, both syncs sit at their inactive level, and `oe` and `pclk_out` are 0. After reset all fields are zero, so both syncs read 1.
- R7: A line is, in order: sync, leading wait, active pixels, trailing wait. Its length is the sum of the four, and a line begins with its sync.
- R8: A frame is, in order: sync lines, leading wait lines, active lines, trailing wait lines. Enabling the block starts a frame at once, with frame sync and line sync asserted together.
- R9: `oe` is 1 only during active pixels of active lines. `px_x` and `px_y` are then the zero-based pixel and line index, and both read 0 while `oe` is 0.
- R10: Configuration writes made while the block is running take effect at the start of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_sel | input | 2 | Word select: 0 control, 1 horizontal, 2 vertical, 3 clock |
| wr_data | input | 32 | Write data |
| pix_en | output | 1 | One-clock pulse per pixel clock period |
| pclk_out | output | 1 | Pixel clock to the panel |
| hsync | output | 1 | Line sync, polarity per R4 |
| vsync | output | 1 | Frame sync, polarity per R4 |
| oe | output | 1 | Output enable during active pixels |
| px_x | output | 12 | Pixel index within the active line |
| px_y | output | 12 | Line index within the active frame |

## Verification
The assertions assume that configuration words change the active timing only at a frame boundary or while the block is disabled. They also assume that every field stays inside its encoded range, so the sums of the line and frame lengths fit the counter width. The stimulus holds to this: it writes the full configuration only while the block is disabled, and the one write made while running changes the horizontal word just after a frame sync has ended. That write is used to show that the running frame keeps its old line length. One run uses the reference 320×240 geometry with a divide of 36 and measures a single line, because a full frame at that setting is too long. A second, small geometry with a divide of 4 is swept over whole frames.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int WORD_W   = 32;
  localparam int PIXF_W   = 10;
  localparam int SYNCF_W  = 6;
  localparam int WAITF_W  = 8;
  localparam int DIVF_W   = 8;
  localparam int VPOL_BIT = 20;
  localparam int HPOL_BIT = 21;
  localparam int FALL_BIT = 22;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_HORZ = 2'd1,
    SEL_VERT = 2'd2,
    SEL_CLK  = 2'd3
  } tg_sel_e;

  typedef struct packed {
    logic [PIXF_W-1:0]  ppl_f;
    logic [SYNCF_W-1:0] hsw_f;
    logic [WAITF_W-1:0] htail_f;
    logic [WAITF_W-1:0] hlead_f;
    logic [PIXF_W-1:0]  lpp_f;
    logic [SYNCF_W-1:0] vsw_f;
    logic [WAITF_W-1:0] vtail_f;
    logic [WAITF_W-1:0] vlead_f;
    logic [DIVF_W-1:0]  div_f;
    logic               vpol;
    logic               hpol;
    logic               pclk_fall;
  } tg_cfg_t;
endpackage

// File: rtl/lcd_tg_cfg.sv
module lcd_tg_cfg
  import lcd_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              frame_load,
  output logic              run,
  output tg_cfg_t           cfg
);
  tg_cfg_t shadow_q;
  tg_cfg_t act_q;
  logic    run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      run_q    <= 1'b0;
    end else if (wr_en) begin
      unique case (tg_sel_e'(wr_sel))
        SEL_CTRL: run_q <= wr_data[0];
        SEL_HORZ: begin
          shadow_q.ppl_f   <= wr_data[9:0];
          shadow_q.hsw_f   <= wr_data[15:10];
          shadow_q.htail_f <= wr_data[23:16];
          shadow_q.hlead_f <= wr_data[31:24];
        end
        SEL_VERT: begin
          shadow_q.lpp_f   <= wr_data[9:0];
          shadow_q.vsw_f   <= wr_data[15:10];
          shadow_q.vtail_f <= wr_data[23:16];
          shadow_q.vlead_f <= wr_data[31:24];
        end
        SEL_CLK: begin
          shadow_q.div_f     <= wr_data[DIVF_W-1:0];
          shadow_q.vpol      <= wr_data[VPOL_BIT];
          shadow_q.hpol      <= wr_data[HPOL_BIT];
          shadow_q.pclk_fall <= wr_data[FALL_BIT];
        end
        default: ;
      endcase
    end
  end

  // working copy follows the shadow while idle, else only at a frame edge
  always_ff @(posedge clk) begin
    if (rst)                       act_q <= '0;
    else if (frame_load || !run_q) act_q <= shadow_q;
  end

  assign run = run_q;
  assign cfg = act_q;

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !frame_load) |=> $stable(act_q));
endmodule

// File: rtl/lcd_tg_pixdiv.sv
module lcd_tg_pixdiv #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [PW-1:0] code,
  output logic          tick,
  output logic          hi_phase
);
  localparam int DW = PW + 2;

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] period;
  logic [DW-1:0] half;

  assign period   = {1'b0, code, 1'b0} + DW'(4);
  assign half     = DW'(code) + DW'(2);
  assign tick     = run && (cnt_q == period - DW'(1));
  assign hi_phase = cnt_q < half;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + DW'(1);
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R3
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt_q < period);
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          adv,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_lead,
  input  logic [CW-1:0] len_act,
  input  logic [CW-1:0] len_tail,
  output logic          wrap,
  output logic          sync_on,
  output logic          act_on,
  output logic [CW-1:0] pos
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] act_lo;
  logic [CW-1:0] act_hi;
  logic [CW-1:0] total;

  assign act_lo = len_sync + len_lead;
  assign act_hi = act_lo + len_act;
  assign total  = act_hi + len_tail;

  assign wrap    = run && adv && (cnt_q == total - CW'(1));
  assign sync_on = run && (cnt_q < len_sync);
  assign act_on  = run && (cnt_q >= act_lo) && (cnt_q < act_hi);
  assign pos     = cnt_q - act_lo;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (adv)    cnt_q <= wrap ? '0 : cnt_q + CW'(1);
  end

  // R7 R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt_q < total);
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [31:0]        wr_data,
  output logic               pix_en,
  output logic               pclk_out,
  output logic               hsync,
  output logic               vsync,
  output logic               oe,
  output logic [COORD_W-1:0] px_x,
  output logic [COORD_W-1:0] px_y
);
  localparam int CW = COORD_W;

  tg_cfg_t cfg;
  logic    run;
  logic    tick, hi_phase;
  logic    h_wrap, h_sync, h_act;
  logic    v_wrap, v_sync, v_act;
  logic [CW-1:0] h_pos, v_pos;

  lcd_tg_cfg u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .frame_load(v_wrap), .run(run), .cfg(cfg)
  );

  lcd_tg_pixdiv #(.PW(DIVF_W)) u_div (
    .clk(clk), .rst(rst), .run(run), .code(cfg.div_f),
    .tick(tick), .hi_phase(hi_phase)
  );

  lcd_tg_axis #(.CW(CW)) u_horz (
    .clk(clk), .rst(rst), .run(run), .adv(tick),
    .len_sync(CW'(cfg.hsw_f) + CW'(1)),
    .len_lead(CW'(cfg.hlead_f) + CW'(1)),
    .len_act (CW'(cfg.ppl_f) + CW'(16)),
    .len_tail(CW'(cfg.htail_f) + CW'(1)),
    .wrap(h_wrap), .sync_on(h_sync), .act_on(h_act), .pos(h_pos)
  );

  lcd_tg_axis #(.CW(CW)) u_vert (
    .clk(clk), .rst(rst), .run(run), .adv(h_wrap),
    .len_sync(CW'(cfg.vsw_f) + CW'(1)),
    .len_lead(CW'(cfg.vlead_f)),
    .len_act (CW'(cfg.lpp_f) + CW'(1)),
    .len_tail(CW'(cfg.vtail_f)),
    .wrap(v_wrap), .sync_on(v_sync), .act_on(v_act), .pos(v_pos)
  );

  logic          oe_d;
  logic          pclk_q, hs_q, vs_q, oe_q, pe_q;
  logic [CW-1:0] x_q, y_q;

  assign oe_d = h_act && v_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      pe_q   <= 1'b0;
      pclk_q <= 1'b0;
      hs_q   <= 1'b1;
      vs_q   <= 1'b1;
      oe_q   <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
    end else begin
      pe_q   <= tick;
      pclk_q <= run && (hi_phase ^ cfg.pclk_fall);
      hs_q   <= h_sync ? cfg.hpol : ~cfg.hpol;
      vs_q   <= v_sync ? cfg.vpol : ~cfg.vpol;
      oe_q   <= oe_d;
      x_q    <= oe_d ? h_pos : '0;
      y_q    <= oe_d ? v_pos : '0;
    end
  end

  assign pix_en   = pe_q;
  assign pclk_out = pclk_q;
  assign hsync    = hs_q;
  assign vsync    = vs_q;
  assign oe       = oe_q;
  assign px_x     = x_q;
  assign px_y     = y_q;

  // R9
  oe_outside_sync_chk: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (hs_q != cfg.hpol) && (vs_q != cfg.vpol));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !oe_q && !pclk_q);

  // R9
  coord_bound_chk: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (x_q < CW'(cfg.ppl_f) + CW'(16)) && (y_q <= CW'(cfg.lpp_f)));
endmodule

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        pix_en, pclk_out, hsync, vsync, oe;
  logic [11:0] px_x, px_y;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  lcd_timing_gen dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pix_en(pix_en), .pclk_out(pclk_out), .hsync(hsync), .vsync(vsync),
    .oe(oe), .px_x(px_x), .px_y(px_y)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // measure one pulse of the chosen sync from its leading edge to the next one
  task automatic meas(input bit vert, input logic lvl, input logic pclk_lvl,
                      output int width, output int period, output int oe_clks,
                      output int ticks, output int maxx, output int maxy,
                      output int edge_bad, output int oe_first);
    logic s, prev_oe;
    bit   ended;
    s = vert ? vsync : hsync;
    while (s == lvl) begin @(negedge clk); s = vert ? vsync : hsync; end
    while (s != lvl) begin @(negedge clk); s = vert ? vsync : hsync; end
    width = 0; period = 0; oe_clks = 0; ticks = 0; maxx = 0; maxy = 0;
    edge_bad = (pclk_out != pclk_lvl) ? 1 : 0;
    oe_first = -1; prev_oe = 1'b0; ended = 1'b0;
    forever begin
      if (s == lvl && !ended) width++;
      else ended = 1'b1;
      if (oe) begin
        oe_clks++;
        if (oe_first < 0) oe_first = period;
        if (int'(px_x) > maxx) maxx = int'(px_x);
        if (int'(px_y) > maxy) maxy = int'(px_y);
        if (!prev_oe && pclk_out != pclk_lvl) edge_bad++;
      end
      if (pix_en) ticks++;
      prev_oe = oe;
      period++;
      @(negedge clk);
      s = vert ? vsync : hsync;
      if (ended && s == lvl) break;
    end
  endtask

  initial begin
    #(150000 * 20);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w, p, oc, tk, mx, my, eb, of, n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 reset state
    chk("R6 reset hsync", int'(hsync), 1);
    chk("R6 reset vsync", int'(vsync), 1);
    chk("R6 reset oe", int'(oe), 0);
    chk("R6 reset pclk", int'(pclk_out), 0);

    // reference geometry, active-low syncs, rising-edge data
    wr(2'd1, 32'h0B10_0930);
    wr(2'd2, 32'h0A01_08EF);
    wr(2'd3, 32'h0000_0010);
    wr(2'd0, 32'h1);
    meas(1'b0, 1'b0, 1'b1, w, p, oc, tk, mx, my, eb, of);
    chk("R1 R4 ref hsync width clocks", w, 3 * 36);
    chk("R1 R7 ref line clocks", p, 352 * 36);
    chk("R3 ref pixel ticks per line", tk, 352);
    chk("R5 ref pclk level at change", eb, 0);

    // small geometry, active-high syncs, falling-edge data
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0000_0400);
    wr(2'd2, 32'h0001_0403);
    wr(2'd3, 32'h0070_0000);
    repeat (3) @(negedge clk);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      if (hsync !== 1'b0 || vsync !== 1'b0 || oe !== 1'b0 || pclk_out !== 1'b0) n++;
      @(negedge clk);
    end
    chk("R6 R4 disabled outputs idle", n, 0);

    wr(2'd0, 32'h1);
    n = 0;
    while (vsync != 1'b1 && n < 10) begin @(negedge clk); n++; end
    chk("R8 enable starts frame promptly", int'(n <= 3), 1);
    chk("R7 R8 syncs start together", int'(hsync), 1);

    meas(1'b0, 1'b1, 1'b0, w, p, oc, tk, mx, my, eb, of);
    chk("R1 small hsync width", w, 8);
    chk("R1 R7 small line clocks", p, 80);

    meas(1'b1, 1'b1, 1'b0, w, p, oc, tk, mx, my, eb, of);
    chk("R2 vsync width clocks", w, 160);
    chk("R2 R8 frame clocks", p, 560);
    chk("R9 oe clocks per frame", oc, 64 * 4);
    chk("R3 pixel ticks per frame", tk, 140);
    chk("R9 max px_x", mx, 15);
    chk("R9 max px_y", my, 3);
    chk("R5 pclk level at change", eb, 0);
    chk("R7 R8 first oe offset", of, (2 * 20 + 3) * 4);

    // R10: change line length mid-frame
    while (vsync != 1'b1) @(negedge clk);
    while (vsync != 1'b0) @(negedge clk);
    wr(2'd1, 32'h0000_0410);
    meas(1'b0, 1'b1, 1'b0, w, p, oc, tk, mx, my, eb, of);
    chk("R10 old line length kept in frame", p, 80);
    while (vsync != 1'b1) @(negedge clk);
    meas(1'b0, 1'b1, 1'b0, w, p, oc, tk, mx, my, eb, of);
    chk("R10 new line length next frame", p, 36 * 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule